// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block holds the command-side protection state of a serial flash status register. It watches decoded opcodes as each command finishes, and it decides whether a write-class command is accepted or refused. For each decision it raises a one-cycle pulse. It also keeps the write-enable latch and two copies of the writable status bits. The non-volatile image is loaded from a parameter at reset. The volatile copy is the one the outputs show and the one that governs protection.

Two protect bits and the write-protect pin level choose how status writes are gated:
- unprotected (writes only need the latch),
- pin-gated,
- locked for the current power session,
- locked permanently.

A second write path starts with a dedicated enable opcode. It updates only the volatile copy, does not need the latch and starts no long write cycle. The external write-cycle timer drives a busy input. When that timer finishes a long operation, the latch is dropped.

Top module: `sr_guard`

## Requirements
- R1: Opcode 06h, when accepted, sets the latch, seen at `stat_lo[1]`. Accepted opcode 04h clears it. Reset and `pwr_up` also clear it.
- R2: A status write (opcode 01h) on the normal path, and any program opcode (02h, 32h, 42h) or erase opcode (20h, 52h, D8h, C7h, 60h, 44h), is refused when the latch is 0.
- R3: The protect mode is the pair {`stat_hi[0]`, `stat_lo[7]`}. In mode 00 a status write needs only the latch. In mode 01 it is refused while `wp_level` is 0 and allowed while `wp_level` is 1.
- R4: In mode 10 every status write is refused whatever `wp_level` is. A `pwr_up` pulse reloads the volatile copy from the non-volatile image, and this lifts a mode 10 that was written only on the volatile path.
- R5: Mode 11 written to the non-volatile image refuses status writes on both paths, and it still does so after `pwr_up`.
- R6: A status write changes only bits 7..2 of `stat_lo` (taken from `wr_data[7:2]`) and bits 6..0 of `stat_hi` (taken from `wr_data[14:8]`). `stat_lo[1:0]` and `stat_hi[7]` never follow `wr_data`, and `stat_hi[7]` reads 0.
- R7: A write-class command whose `byte_aligned` is 0 at `op_done` is refused and changes no state.
- R8: A write-class command arriving while `busy_in` is 1 is refused. `cmd_ok` and `cmd_rej` are each a single-cycle pulse, seen on the cycle after `op_done`.
- R9: Opcode 50h followed directly by 01h writes only the volatile copy. It needs no latch, leaves the latch unchanged and does not arm the latch drop of R11.
- R10: An accepted 04h cancels a pending 50h enable, so a following 01h with the latch at 0 is refused. Any other completed command also consumes the enable.
- R11: After an accepted non-volatile status write, program or erase, the latch stays 1 until `busy_in` falls. It then reads 0 from the next cycle.
- R12: `stat_lo[0]` mirrors `busy_in`. An opcode outside the write class, such as 03h, produces neither `cmd_ok` nor `cmd_rej`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_up | input | 1 | Power-up pulse: reload volatile copy, clear latch and enable |
| op_code | input | 8 | Decoded opcode of the finishing command |
| op_done | input | 1 | Strobe: command finished (chip select rose) |
| byte_aligned | input | 1 | A whole number of bytes was clocked before chip select rose |
| wp_level | input | 1 | Write-protect pin level |
| wr_data | input | 16 | Status write data, second byte in the upper half |
| busy_in | input | 1 | Busy flag from the external write-cycle timer |
| stat_lo | output | 8 | First status byte |
| stat_hi | output | 8 | Second status byte |
| cmd_ok | output | 1 | Pulse: write-class command accepted |
| cmd_rej | output | 1 | Pulse: write-class command refused |

## Verification
The hardest state to reach from the ports is a permanent lock that survives a power-up. Reaching it takes a full non-volatile write of mode 11, a busy cycle to drop the latch, and then `pwr_up`. The bench builds this state last, because no later test could undo it. Before it, the session lock is set up through the volatile path alone. The bench then proves that a power-up clears the session lock, which separates mode 10 from mode 11. The same applies to a volatile enable cancelled by 04h: it only shows as a refusal when the latch is already 0. The bench therefore runs that case right after a power-up.

// File: rtl/sr_guard_pkg.sv
// Package: opcode values and shared types for the status register guard.
// Assumes 8-bit opcodes as delivered by an upstream command decoder.
package sr_guard_pkg;
    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_VOL_EN    = 8'h50;
    localparam logic [7:0] OP_SR_WRITE  = 8'h01;
    localparam logic [7:0] OP_PROG_1    = 8'h02;
    localparam logic [7:0] OP_PROG_4    = 8'h32;
    localparam logic [7:0] OP_ERASE_4K  = 8'h20;
    localparam logic [7:0] OP_ERASE_32K = 8'h52;
    localparam logic [7:0] OP_ERASE_64K = 8'hD8;
    localparam logic [7:0] OP_ERASE_A   = 8'hC7;
    localparam logic [7:0] OP_ERASE_B   = 8'h60;
    localparam logic [7:0] OP_OTP_ERASE = 8'h44;
    localparam logic [7:0] OP_OTP_PROG  = 8'h42;

    typedef enum logic [1:0] {
        PM_SOFT    = 2'b00,
        PM_PIN     = 2'b01,
        PM_SESSION = 2'b10,
        PM_FOREVER = 2'b11
    } prot_mode_t;

    typedef struct packed {
        logic wclass;     // write-class command
        logic is_set;     // latch set
        logic is_clr;     // latch clear
        logic is_venable; // volatile-write enable
        logic is_sr_write;// status register write
        logic is_long;    // starts a timed write cycle
    } cmd_kind_t;
endpackage

// File: rtl/sr_cmd_classify.sv
// Module: sr_cmd_classify
// Sorts an opcode into the command classes the guard acts on.
// Assumes the opcode is stable while op_done is high.
module sr_cmd_classify
    import sr_guard_pkg::*;
(
    input  logic [7:0] op,
    output cmd_kind_t  kind
);
    // Purpose: combinational opcode classification
    always_comb begin
        kind = '0;
        unique case (op)
            OP_LATCH_SET: begin kind.wclass = 1'b1; kind.is_set = 1'b1; end
            OP_LATCH_CLR: begin kind.wclass = 1'b1; kind.is_clr = 1'b1; end
            OP_VOL_EN:    begin kind.wclass = 1'b1; kind.is_venable = 1'b1; end
            OP_SR_WRITE:  begin kind.wclass = 1'b1; kind.is_sr_write = 1'b1; kind.is_long = 1'b1; end
            OP_PROG_1, OP_PROG_4, OP_ERASE_4K, OP_ERASE_32K, OP_ERASE_64K,
            OP_ERASE_A, OP_ERASE_B, OP_OTP_ERASE, OP_OTP_PROG:
                begin kind.wclass = 1'b1; kind.is_long = 1'b1; end
            default: kind = '0;
        endcase
    end
endmodule

// File: rtl/sr_prot_mode.sv
// Module: sr_prot_mode
// Turns the two protect bits and the pin level into a lock decision.
// Assumes the bits come from the volatile (effective) copy.
module sr_prot_mode
    import sr_guard_pkg::*;
(
    input  logic       bit_hi,
    input  logic       bit_lo,
    input  logic       wp_level,
    output prot_mode_t mode,
    output logic       locked
);
    // Purpose: decode mode and whether status writes are blocked
    always_comb begin
        mode = prot_mode_t'({bit_hi, bit_lo});
        unique case (mode)
            PM_SOFT:    locked = 1'b0;
            PM_PIN:     locked = !wp_level;
            PM_SESSION: locked = 1'b1;
            default:    locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_latch_ctl.sv
// Module: sr_latch_ctl
// Holds the write-enable latch, the volatile-write enable and the
// pending flag that drops the latch when the busy timer finishes.
// Assumes accept is only high together with op_done.
module sr_latch_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic op_done,
    input  logic accept,
    input  logic k_set,
    input  logic k_clr,
    input  logic k_venable,
    input  logic k_sr_write,
    input  logic k_long,
    input  logic busy_in,
    output logic latch,
    output logic arm
);
    logic busy_q;
    logic pend;
    logic busy_fall;

    assign busy_fall = pend && busy_q && !busy_in;

    // Purpose: latch, enable and pending-drop state update
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_up) begin
            latch  <= 1'b0;
            arm    <= 1'b0;
            pend   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy_in;
            if (busy_fall) begin
                latch <= 1'b0;
                pend  <= 1'b0;
            end
            if (op_done) arm <= accept && k_venable;
            if (accept) begin
                if (k_set) latch <= 1'b1;
                if (k_clr) latch <= 1'b0;
                if (k_long && !(k_sr_write && arm)) pend <= 1'b1;
            end
        end
    end

    assert_latch_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_fall && !pwr_up && !(accept && k_set)) |=> !latch);

    assert_cancel_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && k_clr) |=> !arm);
endmodule

// File: rtl/sr_image.sv
// Module: sr_image
// Stores the non-volatile and volatile copies of the writable status bits,
// one byte lane per generate step, each with its own write mask.
// Assumes we_nv implies we_vol.
module sr_image #(
    parameter int          BW      = 8,
    parameter logic [2*BW-1:0] NV_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_up,
    input  logic            we_nv,
    input  logic            we_vol,
    input  logic [2*BW-1:0] wr_data,
    output logic [2*BW-1:0] vol
);
    localparam int LANES = 2;
    localparam logic [2*BW-1:0] WMASK = {1'b0, {(BW-1){1'b1}}, {(BW-2){1'b1}}, 2'b00};
    localparam logic [2*BW-1:0] INIT_M = NV_INIT & WMASK;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [BW-1:0] M = WMASK[g*BW +: BW];
        localparam logic [BW-1:0] I = INIT_M[g*BW +: BW];
        logic [BW-1:0] nv_q;
        logic [BW-1:0] vol_q;
        // Purpose: one lane of non-volatile and volatile storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nv_q  <= I;
                vol_q <= I;
            end else if (pwr_up) begin
                vol_q <= nv_q;
            end else begin
                if (we_nv)  nv_q  <= wr_data[g*BW +: BW] & M;
                if (we_vol) vol_q <= wr_data[g*BW +: BW] & M;
            end
        end
        assign vol[g*BW +: BW] = vol_q;
    end
endmodule

// File: rtl/sr_guard.sv
// Module: sr_guard (top)
// Accepts or refuses write-class commands against latch, protect mode,
// pin level, byte alignment and busy; drives the two status bytes.
// Assumes one finished command per op_done pulse and an external timer
// that raises busy_in for every accepted timed operation.
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int          BW      = 8,
    parameter logic [2*BW-1:0] NV_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_up,
    input  logic [7:0]    op_code,
    input  logic          op_done,
    input  logic          byte_aligned,
    input  logic          wp_level,
    input  logic [2*BW-1:0] wr_data,
    input  logic          busy_in,
    output logic [BW-1:0] stat_lo,
    output logic [BW-1:0] stat_hi,
    output logic          cmd_ok,
    output logic          cmd_rej
);
    cmd_kind_t      kind;
    prot_mode_t     mode;
    logic           locked, latch, arm, need, accept, refuse, we_vol, we_nv;
    logic [2*BW-1:0] vol;

    sr_cmd_classify u_cls (.op(op_code), .kind(kind));

    sr_prot_mode u_pm (.bit_hi(vol[BW]), .bit_lo(vol[BW-1]), .wp_level(wp_level),
                       .mode(mode), .locked(locked));

    // Purpose: per-class condition beyond alignment and busy
    always_comb begin
        if (kind.is_sr_write)  need = !locked && (arm || latch);
        else if (kind.is_long) need = latch;
        else                   need = 1'b1;
    end

    assign accept = op_done && kind.wclass && byte_aligned && !busy_in && need;
    assign refuse = op_done && kind.wclass && !accept;
    assign we_vol = accept && kind.is_sr_write;
    assign we_nv  = we_vol && !arm;

    sr_latch_ctl u_lat (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .op_done(op_done),
        .accept(accept), .k_set(kind.is_set), .k_clr(kind.is_clr),
        .k_venable(kind.is_venable), .k_sr_write(kind.is_sr_write),
        .k_long(kind.is_long), .busy_in(busy_in), .latch(latch), .arm(arm)
    );

    sr_image #(.BW(BW), .NV_INIT(NV_INIT)) u_img (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .we_nv(we_nv),
        .we_vol(we_vol), .wr_data(wr_data), .vol(vol)
    );

    // Purpose: registered accept/refuse pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ok  <= 1'b0;
            cmd_rej <= 1'b0;
        end else begin
            cmd_ok  <= accept;
            cmd_rej <= refuse;
        end
    end

    assign stat_lo = {vol[BW-1:2], latch, busy_in};
    assign stat_hi = vol[2*BW-1:BW];

    assert_pwrup_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |=> !stat_lo[1]);
    assert_need_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_code == OP_SR_WRITE && !stat_lo[1] && !arm) |=> !cmd_ok);
    assert_session_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_code == OP_SR_WRITE && stat_hi[0] && !stat_lo[7]) |=> !cmd_ok);
    assert_forever_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_code == OP_SR_WRITE && stat_hi[0] && stat_lo[7]) |=> !cmd_ok);
    assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !byte_aligned) |=> !cmd_ok);
    assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && busy_in) |=> !cmd_ok);
endmodule

// File: tb/sim_sr_guard.sv
module sim_sr_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_up = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        op_done = 1'b0;
    logic        byte_aligned = 1'b1;
    logic        wp_level = 1'b1;
    logic [15:0] wr_data = 16'h0000;
    logic        busy_in = 1'b0;
    logic [7:0]  stat_lo, stat_hi;
    logic        cmd_ok, cmd_rej;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        ok_s, rej_s;

    always #2.5 clk = ~clk;

    sr_guard u0 (.clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .op_code(op_code),
                 .op_done(op_done), .byte_aligned(byte_aligned), .wp_level(wp_level),
                 .wr_data(wr_data), .busy_in(busy_in), .stat_lo(stat_lo),
                 .stat_hi(stat_hi), .cmd_ok(cmd_ok), .cmd_rej(cmd_rej));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one finished command, capture the pulses on the next cycle
    task automatic cmd(input logic [7:0] op, input logic [15:0] d, input logic al);
        @(negedge clk);
        op_code = op; wr_data = d; byte_aligned = al; op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0; byte_aligned = 1'b1;
        ok_s = cmd_ok; rej_s = cmd_rej;
    endtask

    task automatic busy_cycle();
        @(negedge clk); busy_in = 1'b1;
        @(negedge clk); @(negedge clk); busy_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic power_up();
        @(negedge clk); pwr_up = 1'b1;
        @(negedge clk); pwr_up = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset stat_lo", {8'h0, stat_lo}, 16'h0000);
        chk("R6 reset stat_hi", {8'h0, stat_hi}, 16'h0000);
        chk("R8 reset pulses", {14'h0, cmd_ok, cmd_rej}, 16'h0);
    endtask

    task automatic t_latch();
        cmd(8'h06, 16'h0, 1'b1);
        chk("R1 set ok", {15'h0, ok_s}, 16'h1);
        chk("R1 latch set", {8'h0, stat_lo}, 16'h0002);
        cmd(8'h04, 16'h0, 1'b1);
        chk("R1 latch clr", {8'h0, stat_lo}, 16'h0000);
    endtask

    task automatic t_need_latch();
        cmd(8'h01, 16'h00FC, 1'b1);
        chk("R2 write without latch rej", {15'h0, rej_s}, 16'h1);
        chk("R2 status unchanged", {8'h0, stat_lo}, 16'h0000);
    endtask

    task automatic t_mask_busy();
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'h01, 16'hFE7E, 1'b1);
        chk("R3 soft mode write ok", {15'h0, ok_s}, 16'h1);
        chk("R6 lo mask", {8'h0, stat_lo}, 16'h007E);
        chk("R6 hi mask", {8'h0, stat_hi}, 16'h007E);
        @(negedge clk); busy_in = 1'b1;
        @(negedge clk);
        chk("R12 busy mirror", {8'h0, stat_lo}, 16'h007F);
        cmd(8'h06, 16'h0, 1'b1);
        chk("R8 busy rej", {14'h0, ok_s, rej_s}, 16'h1);
        @(negedge clk);
        chk("R8 rej one cycle", {15'h0, cmd_rej}, 16'h0);
        chk("R11 latch held while busy", {15'h0, stat_lo[1]}, 16'h1);
        busy_in = 1'b0;
        @(negedge clk);
        chk("R11 latch drops after busy", {8'h0, stat_lo}, 16'h007C);
    endtask

    task automatic t_align();
        cmd(8'h06, 16'h0, 1'b0);
        chk("R7 misaligned rej", {14'h0, ok_s, rej_s}, 16'h1);
        chk("R7 latch unchanged", {8'h0, stat_lo}, 16'h007C);
    endtask

    task automatic t_program();
        cmd(8'h02, 16'h0, 1'b1);
        chk("R2 program without latch rej", {15'h0, rej_s}, 16'h1);
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'hD8, 16'h0, 1'b1);
        chk("R11 erase ok", {15'h0, ok_s}, 16'h1);
        chk("R11 latch kept", {15'h0, stat_lo[1]}, 16'h1);
        busy_cycle();
        chk("R11 latch cleared", {15'h0, stat_lo[1]}, 16'h0);
    endtask

    task automatic t_pin_mode();
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'h01, 16'h0080, 1'b1);
        busy_cycle();
        chk("R3 pin mode stored", {8'h0, stat_lo}, 16'h0080);
        wp_level = 1'b0;
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'h01, 16'h0000, 1'b1);
        chk("R3 wp low rej", {14'h0, ok_s, rej_s}, 16'h1);
        chk("R3 wp low unchanged", {8'h0, stat_lo}, 16'h0082);
        wp_level = 1'b1;
        cmd(8'h01, 16'h0000, 1'b1);
        chk("R3 wp high ok", {15'h0, ok_s}, 16'h1);
        busy_cycle();
        chk("R3 wp high written", {8'h0, stat_lo}, 16'h0000);
    endtask

    task automatic t_volatile();
        cmd(8'h50, 16'h0, 1'b1);
        cmd(8'h01, 16'h000C, 1'b1);
        chk("R9 volatile ok", {15'h0, ok_s}, 16'h1);
        chk("R9 volatile value no latch", {8'h0, stat_lo}, 16'h000C);
        power_up();
        chk("R9 powerup restores image", {8'h0, stat_lo}, 16'h0000);
    endtask

    task automatic t_cancel();
        cmd(8'h50, 16'h0, 1'b1);
        cmd(8'h04, 16'h0, 1'b1);
        cmd(8'h01, 16'h000C, 1'b1);
        chk("R10 cancelled enable rej", {14'h0, ok_s, rej_s}, 16'h1);
        chk("R10 status unchanged", {8'h0, stat_lo}, 16'h0000);
        cmd(8'h03, 16'h0, 1'b1);
        chk("R12 read no pulse", {14'h0, ok_s, rej_s}, 16'h0);
    endtask

    task automatic t_session();
        cmd(8'h50, 16'h0, 1'b1);
        cmd(8'h01, 16'h0100, 1'b1);
        chk("R4 session mode set", {stat_hi, stat_lo}, 16'h0100);
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'h01, 16'h0000, 1'b1);
        chk("R4 locked with wp high", {14'h0, ok_s, rej_s}, 16'h1);
        chk("R4 bits kept", {8'h0, stat_hi}, 16'h0001);
        power_up();
        chk("R4 powerup lifts", {stat_hi, stat_lo}, 16'h0000);
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'h01, 16'h0004, 1'b1);
        chk("R4 write after powerup", {8'h0, stat_lo}, 16'h0006);
        busy_cycle();
    endtask

    task automatic t_forever();
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'h01, 16'h0180, 1'b1);
        busy_cycle();
        power_up();
        chk("R5 image after powerup", {stat_hi, stat_lo}, 16'h0180);
        cmd(8'h06, 16'h0, 1'b1);
        cmd(8'h01, 16'h0000, 1'b1);
        chk("R5 normal path rej", {14'h0, ok_s, rej_s}, 16'h1);
        cmd(8'h50, 16'h0, 1'b1);
        cmd(8'h01, 16'h0000, 1'b1);
        chk("R5 volatile path rej", {14'h0, ok_s, rej_s}, 16'h1);
        chk("R5 bits kept", {stat_hi, stat_lo}, 16'h0182);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_need_latch();
        t_mask_busy();
        t_align();
        t_program();
        t_pin_mode();
        t_volatile();
        t_cancel();
        t_session();
        t_forever();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule